// File: doc/BRIEF.md
# Predicated Vector Load/Store Address Sequencer

This block turns one vector memory instruction of VL elements into a stream of per-element memory requests. At start it captures a base address, an immediate, an element width code, an address mode (unit stride, element stride or indexed), a table of per-element addresses, and two independent predicate masks. One mask governs the source element index and the other governs the destination register index. The block walks both indices, skipping positions whose mask bit is clear. For every pair it accepts, it offers an address, the source index, the destination index and a last flag over a valid/ready handshake.

A fault line is sampled with each accepted request. In fail-first operation a fault on a later element, or an element that would begin a new aligned line, shortens the vector length to a nonzero value instead of raising an exception. A fault on the first accepted element is reported as an exception, exactly as for a scalar access. The controller is a four-state machine. IDLE waits for start and moves to SEEK. SEEK searches both masks and moves either to ISSUE (a pair was found) or to DONE (walk finished or truncated). ISSUE holds the request until ready, then moves to SEEK on success or to DONE on a fault. DONE pulses the completion output and returns to IDLE.

Top module: `vls_seq`

## Requirements
- R1: Width code 0, 1, 2 and 3 selects 1, 2, 4 and 8 byte elements. In unit-stride mode (address scalar, stride select 0), the address of source element i is base + immediate + (i << code).
- R2: In element-stride mode (address scalar, stride select 1), the address of source element i is base + immediate × i.
- R3: When the address operand is marked vector, the address of source element i is entry i of the per-element address table (bits i×AW upward), and stride select has no effect.
- R4: Each issued source index has its source mask bit set and each destination index has its destination mask bit set. Both indices rise strictly, skipping clear bits independently.
- R5: The walk ends when either index reaches VL. With no eligible pair (all-zero mask or VL = 0), no request is made and done rises two clock edges after the start edge.
- R6: While valid is high and ready is low, valid stays high and address and indices hold their values.
- R7: Last is high exactly on the request after which no further source or destination eligible element remains below VL.
- R8: Done is a single-cycle pulse. After a normal finish, the reported length equals VL. After reset, valid and done are low.
- R9: Outside fail-first, a fault on any accepted request ends the walk with the exception flag set and the reported length equal to VL. No further request follows.
- R10: In fail-first, a fault on the first accepted request is reported as in R9 (exception set, length VL).
- R11: In fail-first, a fault on a later request ends the walk without exception. The reported length equals that request's source index, which is nonzero.
- R12: In fail-first with line truncation enabled, a later element whose address is a multiple of LINE_BYTES (16 by default) is not issued. The walk ends without exception and the length equals its source index. Without fail-first, the line truncation input has no effect.
- R13: A start pulse while a walk is in progress is ignored; the running walk keeps its captured operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vl | input | CNT_W | Vector length |
| base | input | AW | Base address |
| imm | input | AW | Immediate offset or stride |
| width_sel | input | 2 | Element width code |
| addr_is_vec | input | 1 | Address operand is a vector (indexed mode) |
| stride_sel | input | 1 | 0 unit stride, 1 element stride |
| vec_addr | input | MAX_VL*AW | Per-element address table |
| src_mask | input | MAX_VL | Source predicate |
| dst_mask | input | MAX_VL | Destination predicate |
| ffirst | input | 1 | Fail-first operation |
| line_trunc | input | 1 | Allow truncation at line boundaries in fail-first |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request taken |
| req_addr | output | AW | Element address |
| req_src_idx | output | IDX_W | Source element index |
| req_dst_idx | output | IDX_W | Destination element index |
| req_last | output | 1 | Final eligible pair |
| req_fault | input | 1 | Fault for the request taken this cycle |
| done | output | 1 | Walk finished (one cycle) |
| done_vl | output | CNT_W | Final vector length |
| exc | output | 1 | Exception, valid with done |

## Verification
Start is taken on a clock edge. The first request is valid after the second edge, and after each accepted handshake the next request appears two edges later, because SEEK and ISSUE each take one edge. Done follows one edge after a faulting handshake or after a SEEK that finds nothing or truncates, so an empty walk shows done two edges after start. The bench samples outputs on falling edges and compares each fresh request to a model walk built from the requirements. On stalled cycles it compares against the values held from the previous cycle. When done appears, it compares the request count, length and exception against the table entry; for empty walks it also checks that done appears on exactly the second sample.

// File: rtl/vls_pkg.sv
package vls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_ISSUE,
        ST_DONE
    } vls_state_e;

    typedef enum logic [1:0] {
        AM_UNIT,
        AM_ELEM,
        AM_INDEX
    } addr_mode_e;
endpackage

// File: rtl/vls_pred_walk.sv
module vls_pred_walk #(
    parameter int MAX_VL = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [CNT_W-1:0]  from,
    input  logic [CNT_W-1:0]  vl,
    output logic [IDX_W-1:0]  idx,
    output logic              found
);
    // lowest set mask position in [from, vl)
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int k = MAX_VL - 1; k >= 0; k--) begin
            if (mask[k] && (CNT_W'(k) >= from) && (CNT_W'(k) < vl)) begin
                idx   = IDX_W'(k);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int AW         = 32,
    parameter int MAX_VL     = 8,
    parameter int IDX_W      = 3,
    parameter int LINE_BYTES = 16
) (
    input  addr_mode_e           mode,
    input  logic [1:0]           wsel,
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        imm,
    input  logic [MAX_VL*AW-1:0] vec_addr,
    input  logic [IDX_W-1:0]     idx,
    output logic [AW-1:0]        addr,
    output logic                 aligned
);
    localparam int LINE_LG = $clog2(LINE_BYTES);

    logic [AW-1:0] idx_ext;
    logic [AW-1:0] unit_addr;
    logic [AW-1:0] elem_addr;

    assign idx_ext   = {{(AW-IDX_W){1'b0}}, idx};
    assign unit_addr = base + imm + (idx_ext << wsel);
    assign elem_addr = base + imm * idx_ext;

    always_comb begin
        unique case (mode)
            AM_UNIT:  addr = unit_addr;
            AM_ELEM:  addr = elem_addr;
            AM_INDEX: addr = vec_addr[idx*AW +: AW];
            default:  addr = unit_addr;
        endcase
    end

    assign aligned = (addr[LINE_LG-1:0] == '0);
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cfg_load,
    input  logic [CNT_W-1:0] vl_q,
    input  logic             ffirst_q,
    input  logic             trunc_q,
    input  logic             src_found,
    input  logic             dst_found,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             src_more,
    input  logic             dst_more,
    input  logic [AW-1:0]    cand_addr,
    input  logic             cand_aligned,
    output logic [CNT_W-1:0] cur_src,
    output logic [CNT_W-1:0] cur_dst,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [AW-1:0]    req_addr,
    output logic [IDX_W-1:0] req_src_idx,
    output logic [IDX_W-1:0] req_dst_idx,
    output logic             req_last,
    input  logic             req_fault,
    output logic             done,
    output logic [CNT_W-1:0] done_vl,
    output logic             exc
);
    vls_state_e state_q, state_d;
    logic       began_q;
    logic       pair_ok;
    logic       trunc_hit;

    assign pair_ok   = src_found && dst_found;
    assign trunc_hit = ffirst_q && trunc_q && began_q && cand_aligned;
    assign cfg_load  = (state_q == ST_IDLE) && start;
    assign done      = (state_q == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SEEK;
            ST_SEEK:  state_d = (!pair_ok || trunc_hit) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = req_fault ? ST_DONE : ST_SEEK;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src     <= '0;
            cur_dst     <= '0;
            began_q     <= 1'b0;
            req_valid   <= 1'b0;
            req_addr    <= '0;
            req_src_idx <= '0;
            req_dst_idx <= '0;
            req_last    <= 1'b0;
            done_vl     <= '0;
            exc         <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_src <= '0;
                        cur_dst <= '0;
                        began_q <= 1'b0;
                        exc     <= 1'b0;
                    end
                end
                ST_SEEK: begin
                    if (!pair_ok) begin
                        done_vl <= vl_q;
                    end else if (trunc_hit) begin
                        done_vl <= CNT_W'(src_idx);
                    end else begin
                        req_valid   <= 1'b1;
                        req_addr    <= cand_addr;
                        req_src_idx <= src_idx;
                        req_dst_idx <= dst_idx;
                        req_last    <= !(src_more && dst_more);
                    end
                end
                ST_ISSUE: begin
                    if (req_ready) begin
                        req_valid <= 1'b0;
                        if (req_fault) begin
                            if (ffirst_q && began_q) begin
                                done_vl <= CNT_W'(req_src_idx);
                            end else begin
                                exc     <= 1'b1;
                                done_vl <= vl_q;
                            end
                        end else begin
                            began_q <= 1'b1;
                            cur_src <= CNT_W'(req_src_idx) + CNT_W'(1);
                            cur_dst <= CNT_W'(req_dst_idx) + CNT_W'(1);
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                   && $stable(req_src_idx) && $stable(req_dst_idx));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    exc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && exc |-> done_vl == vl_q);
    // R11
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && (vl_q != '0) |-> done_vl != '0);
    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (CNT_W'(req_src_idx) < vl_q) && (CNT_W'(req_dst_idx) < vl_q));
    // R9
    fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_fault |=> done);
endmodule

// File: rtl/vls_seq.sv
module vls_seq
    import vls_pkg::*;
#(
    parameter int AW         = 32,
    parameter int MAX_VL     = 8,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W     = $clog2(MAX_VL),
    localparam int CNT_W     = $clog2(MAX_VL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     vl,
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        imm,
    input  logic [1:0]           width_sel,
    input  logic                 addr_is_vec,
    input  logic                 stride_sel,
    input  logic [MAX_VL*AW-1:0] vec_addr,
    input  logic [MAX_VL-1:0]    src_mask,
    input  logic [MAX_VL-1:0]    dst_mask,
    input  logic                 ffirst,
    input  logic                 line_trunc,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    output logic [IDX_W-1:0]     req_src_idx,
    output logic [IDX_W-1:0]     req_dst_idx,
    output logic                 req_last,
    input  logic                 req_fault,
    output logic                 done,
    output logic [CNT_W-1:0]     done_vl,
    output logic                 exc
);
    logic                 cfg_load;
    logic [CNT_W-1:0]     vl_q;
    logic [AW-1:0]        base_q;
    logic [AW-1:0]        imm_q;
    logic [1:0]           wsel_q;
    addr_mode_e           mode_q;
    logic [MAX_VL*AW-1:0] vec_q;
    logic [MAX_VL-1:0]    smask_q;
    logic [MAX_VL-1:0]    dmask_q;
    logic                 ffirst_q;
    logic                 trunc_q;

    logic [CNT_W-1:0]     cur_src;
    logic [CNT_W-1:0]     cur_dst;
    logic [IDX_W-1:0]     hit_idx  [2];
    logic                 hit_found[2];
    logic                 more_found[2];
    logic [IDX_W-1:0]     more_idx [2];
    logic [AW-1:0]        cand_addr;
    logic                 cand_aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q     <= '0;
            base_q   <= '0;
            imm_q    <= '0;
            wsel_q   <= '0;
            mode_q   <= AM_UNIT;
            vec_q    <= '0;
            smask_q  <= '0;
            dmask_q  <= '0;
            ffirst_q <= 1'b0;
            trunc_q  <= 1'b0;
        end else if (cfg_load) begin
            vl_q     <= vl;
            base_q   <= base;
            imm_q    <= imm;
            wsel_q   <= width_sel;
            mode_q   <= addr_is_vec ? AM_INDEX : (stride_sel ? AM_ELEM : AM_UNIT);
            vec_q    <= vec_addr;
            smask_q  <= src_mask;
            dmask_q  <= dst_mask;
            ffirst_q <= ffirst;
            trunc_q  <= line_trunc;
        end
    end

    // walker 0 follows the source mask, walker 1 the destination mask
    for (genvar g = 0; g < 2; g++) begin : g_walk
        logic [MAX_VL-1:0] m;
        logic [CNT_W-1:0]  pos;
        assign m   = (g == 0) ? smask_q : dmask_q;
        assign pos = (g == 0) ? cur_src : cur_dst;

        vls_pred_walk #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_hit (
            .mask (m),
            .from (pos),
            .vl   (vl_q),
            .idx  (hit_idx[g]),
            .found(hit_found[g])
        );

        vls_pred_walk #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_more (
            .mask (m),
            .from (CNT_W'(hit_idx[g]) + CNT_W'(1)),
            .vl   (vl_q),
            .idx  (more_idx[g]),
            .found(more_found[g])
        );
    end

    vls_addr_gen #(.AW(AW), .MAX_VL(MAX_VL), .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) u_agen (
        .mode    (mode_q),
        .wsel    (wsel_q),
        .base    (base_q),
        .imm     (imm_q),
        .vec_addr(vec_q),
        .idx     (hit_idx[0]),
        .addr    (cand_addr),
        .aligned (cand_aligned)
    );

    vls_ctrl #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_load    (cfg_load),
        .vl_q        (vl_q),
        .ffirst_q    (ffirst_q),
        .trunc_q     (trunc_q),
        .src_found   (hit_found[0]),
        .dst_found   (hit_found[1]),
        .src_idx     (hit_idx[0]),
        .dst_idx     (hit_idx[1]),
        .src_more    (more_found[0]),
        .dst_more    (more_found[1]),
        .cand_addr   (cand_addr),
        .cand_aligned(cand_aligned),
        .cur_src     (cur_src),
        .cur_dst     (cur_dst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_src_idx (req_src_idx),
        .req_dst_idx (req_dst_idx),
        .req_last    (req_last),
        .req_fault   (req_fault),
        .done        (done),
        .done_vl     (done_vl),
        .exc         (exc)
    );

    // R4
    pred_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> smask_q[req_src_idx] && dmask_q[req_dst_idx]);
    // R3
    indexed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (mode_q == AM_INDEX) |-> req_addr == vec_q[req_src_idx*AW +: AW]);
    // R13
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $stable(vl_q) && $stable(smask_q));
endmodule

// File: tb/vls_seq_tb.sv
module vls_seq_tb;
    localparam int AW = 32;
    localparam int MAX_VL = 8;
    localparam int CNT_W = 4;
    localparam int IDX_W = 3;
    localparam int NCASE = 17;

    typedef struct packed {
        logic [1:0]  md;   // 0 unit, 1 element stride, 2 indexed
        logic [1:0]  w;
        logic [3:0]  vl;
        logic [7:0]  sm;
        logic [7:0]  dm;
        logic        ff;
        logic        lt;
        logic [3:0]  fa;   // request number that faults, 15 = none
        logic        st;   // stall ready on alternate cycles
        logic        rs;   // extra start while busy
        logic [15:0] bs;
        logic [15:0] im;
        logic [3:0]  en;   // expected request count
        logic [3:0]  ev;   // expected final length
        logic        ex;   // expected exception
    } vec_t;

    localparam vec_t TBL [NCASE] = '{
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0020, 4'd8, 4'd8, 1'b0},
        '{2'd1, 2'd3, 4'd5, 8'h1F, 8'h1F, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h2000, 16'h0018, 4'd5, 4'd5, 1'b0},
        '{2'd2, 2'd0, 4'd6, 8'h2D, 8'h3F, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'd4, 4'd6, 1'b0},
        '{2'd0, 2'd0, 4'd8, 8'hAA, 8'h55, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0, 16'h3000, 16'h0001, 4'd4, 4'd8, 1'b0},
        '{2'd0, 2'd1, 4'd8, 8'h0F, 8'h03, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd2, 4'd8, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'h00, 8'h00, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd0, 4'd8, 1'b0},
        '{2'd0, 2'd3, 4'd1, 8'h01, 8'h01, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h4000, 16'h0008, 4'd1, 4'd1, 1'b0},
        '{2'd0, 2'd2, 4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd0, 4'd0, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd3, 4'd8, 1'b1},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd1, 4'd8, 1'b1},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd4, 4'd3, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hF5, 8'hFF, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd3, 4'd4, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd4, 4'd4, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 16'h1008, 16'h0000, 4'd2, 4'd2, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 16'h1000, 16'h0000, 4'd8, 4'd8, 1'b0},
        '{2'd0, 2'd1, 4'd7, 8'h7F, 8'h7E, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 16'h0100, 16'h0002, 4'd6, 4'd7, 1'b0},
        '{2'd0, 2'd2, 4'd8, 8'hFF, 8'hFF, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 16'h1000, 16'h0000, 4'd8, 4'd8, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CNT_W-1:0]     vl = '0;
    logic [AW-1:0]        base = '0;
    logic [AW-1:0]        imm = '0;
    logic [1:0]           width_sel = '0;
    logic                 addr_is_vec = 1'b0;
    logic                 stride_sel = 1'b0;
    logic [MAX_VL*AW-1:0] vec_addr;
    logic [MAX_VL-1:0]    src_mask = '0;
    logic [MAX_VL-1:0]    dst_mask = '0;
    logic                 ffirst = 1'b0;
    logic                 line_trunc = 1'b0;
    logic                 req_valid;
    logic                 req_ready = 1'b0;
    logic [AW-1:0]        req_addr;
    logic [IDX_W-1:0]     req_src_idx;
    logic [IDX_W-1:0]     req_dst_idx;
    logic                 req_last;
    logic                 req_fault = 1'b0;
    logic                 done;
    logic [CNT_W-1:0]     done_vl;
    logic                 exc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vls_seq #(.AW(AW), .MAX_VL(MAX_VL), .LINE_BYTES(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base(base), .imm(imm),
        .width_sel(width_sel), .addr_is_vec(addr_is_vec), .stride_sel(stride_sel),
        .vec_addr(vec_addr), .src_mask(src_mask), .dst_mask(dst_mask),
        .ffirst(ffirst), .line_trunc(line_trunc), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_src_idx(req_src_idx),
        .req_dst_idx(req_dst_idx), .req_last(req_last), .req_fault(req_fault),
        .done(done), .done_vl(done_vl), .exc(exc)
    );

    always_comb begin
        for (int k = 0; k < MAX_VL; k++) vec_addr[k*AW +: AW] = 32'h8000 + 32'(k) * 32'h111;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(input logic [7:0] m, input int from, input int n);
        for (int k = from; k < n; k++) if (m[k]) return k;
        return 99;
    endfunction

    function automatic logic [31:0] model_addr(input vec_t v, input int i);
        case (v.md)
            2'd0:    return 32'(v.bs) + 32'(v.im) + (32'(i) << v.w);
            2'd1:    return 32'(v.bs) + 32'(v.im) * 32'(i);
            default: return 32'h8000 + 32'(i) * 32'h111;
        endcase
    endfunction

    task automatic run_case(input int c, input vec_t v);
        int n = 0, mi = 0, mj = 0, ei = 0, ej = 0, cyc = 0;
        bit stalled = 1'b0, fin = 1'b0;
        logic [31:0] held = '0;
        @(negedge clk);
        vl = v.vl; base = 32'(v.bs); imm = 32'(v.im); width_sel = v.w;
        addr_is_vec = (v.md == 2'd2); stride_sel = (v.md != 2'd0);
        src_mask = v.sm; dst_mask = v.dm; ffirst = v.ff; line_trunc = v.lt;
        req_ready = 1'b0; req_fault = 1'b0; start = 1'b1;
        while (!fin && cyc < 200) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (v.rs && cyc == 3) begin
                start = 1'b1; vl = 4'd2; src_mask = 8'h01;   // R13 ignored while busy
            end
            req_ready = 1'b0; req_fault = 1'b0;
            if (req_valid) begin
                if (stalled) begin
                    check(req_addr == held, "R6 held address", req_addr, held);
                end else begin
                    ei = nxt(v.sm, mi, int'(v.vl));
                    ej = nxt(v.dm, mj, int'(v.vl));
                    check(req_addr == model_addr(v, ei), "R1/R2/R3 address", req_addr, model_addr(v, ei));
                    check(int'(req_src_idx) == ei && int'(req_dst_idx) == ej, "R4 indices",
                          {req_src_idx, 8'h0, 5'h0, req_dst_idx}, 32'(ei * 65536 + ej));
                    check(req_last == (nxt(v.sm, ei + 1, int'(v.vl)) == 99 || nxt(v.dm, ej + 1, int'(v.vl)) == 99),
                          "R7 last", 32'(req_last), 32'(!req_last));
                end
                if (!v.st || cyc[0]) begin
                    req_ready = 1'b1;
                    req_fault = (n == int'(v.fa));
                    n++; mi = ei + 1; mj = ej + 1; stalled = 1'b0;
                end else begin
                    stalled = 1'b1; held = req_addr;
                end
            end
            if (done) begin
                fin = 1'b1;
                check(n == int'(v.en), "R5/R9/R11/R12 request count", 32'(n), 32'(v.en));
                check(done_vl == v.ev, "R8/R11/R12/R13 final length", 32'(done_vl), 32'(v.ev));
                check(exc == v.ex, "R9/R10 exception", 32'(exc), 32'(v.ex));
                if (v.en == 4'd0) check(cyc == 2, "R5 empty walk timing", 32'(cyc), 32'd2);
            end
        end
        check(fin, "R8 done reached", 32'(fin), 32'd1);
        @(negedge clk);
        check(!done, "R8 done single cycle", 32'(done), 32'd0);
        check(!req_valid, "R9 no request after end", 32'(req_valid), 32'd0);
        $display("case %0d complete", c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!req_valid && !done, "R8 reset state", {30'h0, req_valid, done}, 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < NCASE; c++) run_case(c, TBL[c]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule